// File: doc/BRIEF.md
# Interpolation Filter Multiply-Accumulate Engine

This engine produces one output word of a two-times upsampling filter. Each output is the sum of seven products. Each product multiplies a 12-bit signed sample, fetched from an external history store through an address port, by an 8-bit signed weight held in a small internal weight file. The engine forms each product bit-serially by add-and-shift over the weight bits. It uses one adder, which also serves the running total. It saturates the finished total to 12 bits for the pulse-width stage that follows.

A single start pulse launches a computation. An 8-bit step counter then runs the fixed schedule, and its count is decoded into the controls for each cycle. Each tap gets a 16-count slot: one count to load the sample, eight counts of shift-add, one count to accumulate, and six idle counts. After the seven slots, a finish count publishes the result with a one-cycle done pulse. The whole run uses 113 counts of the 128-cycle budget for each interpolated output.

The sequencer has two states. In `SQ_IDLE` it waits, and on an accepted start it moves to `SQ_RUN` with the counter at zero. In `SQ_RUN` the counter steps every cycle. On the finish count the sequencer returns to `SQ_IDLE`. Within `SQ_RUN` the count decodes to the phases `PH_LOAD`, `PH_MUL`, `PH_ACC`, `PH_WAIT` and `PH_FINISH`. Outside a run the phase is `PH_IDLE`.

Top module: `interp_mac`

## Requirements
- R1: After reset, `result` is 0, `done` is 0 and `smp_addr` is 0. While no computation runs, `smp_addr` stays 0.
- R2: Each tap product equals floor(sample × weight / 256), with both operands in two's complement. The weight's most significant bit counts as −128, so sample −2048 with weight −128 gives +1024, and sample −3 with weight 1 gives −1.
- R3: `result` is the sum of the seven tap products, clamped to the range −2048 to +2047 and presented as a 12-bit two's-complement value.
- R4: During tap slot k (k = 0 to 6), `smp_addr` equals k and holds steady for the whole slot. Sample address k is paired with weight entry k.
- R5: Let the edge that samples `start` be edge 0. Then `done` is high for exactly the one cycle that follows edge 113. `result` changes only in a cycle where `done` is high.
- R6: A `start` pulse received while a computation runs is ignored: the run continues, and its timing and result are unchanged.
- R7: When `wt_we` is high at a clock edge and `wt_addr` is 0 to 6, `wt_data` replaces that weight entry. A write to address 7 changes nothing.
- R8: The step counter stays below 128 throughout a run, which keeps each output within its 128-cycle budget.
- R9: Each accepted start clears the running total, so consecutive runs do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a computation when idle |
| wt_we | input | 1 | Weight write enable |
| wt_addr | input | 3 | Weight entry to write |
| wt_data | input | 8 | Signed weight value |
| smp_addr | output | 3 | Index of the history sample being requested |
| smp_data | input | 12 | Signed sample returned for `smp_addr`, same cycle |
| result | output | 12 | Saturated signed filter output |
| done | output | 1 | One-cycle pulse marking a new `result` |

## Verification
A single active tap with a small positive sample checks the basic scaling. Negative samples with unit weights show whether the truncation floors toward minus infinity rather than toward zero. The most negative sample times the most negative weight shows whether the last shift-add step subtracts rather than adds. Several mixed-sign patterns with all seven taps active expose any pairing error between sample addresses and weight entries. Worst-case patterns in both directions drive the total past 12 bits and tell saturation apart from wraparound. A restart attempt in the middle of a run, a write to the unused weight address, and consecutive runs with different data show whether the schedule restarts, a weight is corrupted, or the running total carries over between outputs.

// File: rtl/interp_pkg.sv
package interp_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_MUL,
        PH_ACC,
        PH_WAIT,
        PH_FINISH
    } phase_e;

    typedef enum logic {
        SQ_IDLE,
        SQ_RUN
    } seq_e;
endpackage

// File: rtl/interp_seq.sv
module interp_seq
    import interp_pkg::*;
#(
    parameter int TAPS   = 7,
    parameter int COEF_W = 8,
    parameter int CNT_W  = 8,
    parameter int SLOT_W = 4,
    parameter int TERM_W = 3,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              accept,
    output logic              busy,
    output logic [CNT_W-1:0]  step_cnt,
    output phase_e            phase,
    output logic [TERM_W-1:0] term,
    output logic [BIT_W-1:0]  bit_idx
);
    localparam logic [CNT_W-1:0]  FIN_CNT  = CNT_W'(TAPS << SLOT_W);
    localparam logic [SLOT_W-1:0] LAST_MUL = SLOT_W'(COEF_W);
    localparam logic [SLOT_W-1:0] ACC_SLOT = SLOT_W'(COEF_W + 1);

    seq_e              st_q;
    logic [SLOT_W-1:0] slot;

    assign accept = (st_q == SQ_IDLE) && start;
    assign busy   = (st_q == SQ_RUN);
    assign slot   = step_cnt[SLOT_W-1:0];

    // State register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SQ_IDLE;
            step_cnt <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    step_cnt <= '0;
                    if (start) st_q <= SQ_RUN;
                end
                SQ_RUN: begin
                    if (step_cnt == FIN_CNT) begin
                        st_q     <= SQ_IDLE;
                        step_cnt <= '0;
                    end else begin
                        step_cnt <= step_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Count decode into per-cycle controls
    always_comb begin
        phase   = PH_IDLE;
        term    = '0;
        bit_idx = BIT_W'(slot - 1'b1);
        unique case (st_q)
            SQ_IDLE: phase = PH_IDLE;
            SQ_RUN: begin
                term = step_cnt[SLOT_W+TERM_W-1:SLOT_W];
                if (step_cnt == FIN_CNT) begin
                    phase = PH_FINISH;
                    term  = '0;
                end else if (slot == '0)       phase = PH_LOAD;
                else if (slot <= LAST_MUL)     phase = PH_MUL;
                else if (slot == ACC_SLOT)     phase = PH_ACC;
                else                           phase = PH_WAIT;
            end
        endcase
    end
endmodule

// File: rtl/interp_coef_rf.sv
module interp_coef_rf #(
    parameter int TAPS   = 7,
    parameter int COEF_W = 8,
    parameter int TERM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [TERM_W-1:0] waddr,
    input  logic [COEF_W-1:0] wdata,
    input  logic [TERM_W-1:0] raddr,
    output logic [COEF_W-1:0] rdata
);
    logic [COEF_W-1:0] regs [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                                 regs[g] <= '0;
            else if (we && (waddr == TERM_W'(g)))       regs[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < TAPS; i++)
            if (raddr == TERM_W'(i)) rdata = regs[i];
    end
endmodule

// File: rtl/interp_datapath.sv
module interp_datapath
    import interp_pkg::*;
#(
    parameter int SMP_W  = 12,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 15,
    parameter int BIT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  phase_e           phase,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic [COEF_W-1:0] coef,
    input  logic [SMP_W-1:0] smp_in,
    output logic [SMP_W-1:0] result,
    output logic             done
);
    localparam int PROD_W = SMP_W + 1;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (SMP_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(1 << (SMP_W - 1));

    logic signed [SMP_W-1:0]  smp_q;
    logic signed [PROD_W-1:0] prod_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  opa, opb, sum, smp_ext, prod_ext;
    logic        [SMP_W-1:0]  sat;

    assign smp_ext  = {{(ACC_W-SMP_W){smp_q[SMP_W-1]}}, smp_q};
    assign prod_ext = {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};

    // Operand steering for the single shared adder
    always_comb begin
        opa = '0;
        opb = '0;
        unique case (phase)
            PH_MUL: begin
                opa = prod_ext;
                if (coef[bit_idx])
                    opb = (bit_idx == BIT_W'(COEF_W - 1)) ? -smp_ext : smp_ext;
            end
            PH_ACC: begin
                opa = acc_q;
                opb = prod_ext;
            end
            default: ;
        endcase
        sum = opa + opb;
    end

    always_comb begin
        if (acc_q > SAT_HI)      sat = {1'b0, {(SMP_W-1){1'b1}}};
        else if (acc_q < SAT_LO) sat = {1'b1, {(SMP_W-1){1'b0}}};
        else                     sat = acc_q[SMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q  <= '0;
            prod_q <= '0;
            acc_q  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clr) acc_q <= '0;
            unique case (phase)
                PH_LOAD: begin
                    smp_q  <= smp_in;
                    prod_q <= '0;
                end
                PH_MUL:    prod_q <= sum[PROD_W:1];
                PH_ACC:    acc_q  <= sum;
                PH_FINISH: begin
                    result <= sat;
                    done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/interp_mac.sv
module interp_mac
    import interp_pkg::*;
#(
    parameter int SMP_W  = 12,
    parameter int COEF_W = 8,
    parameter int TAPS   = 7,
    parameter int CNT_W  = 8,
    parameter int SLOT_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       wt_we,
    input  logic [$clog2(TAPS+1)-1:0]  wt_addr,
    input  logic [COEF_W-1:0]          wt_data,
    output logic [$clog2(TAPS+1)-1:0]  smp_addr,
    input  logic [SMP_W-1:0]           smp_data,
    output logic [SMP_W-1:0]           result,
    output logic                       done
);
    localparam int TERM_W = $clog2(TAPS + 1);
    localparam int BIT_W  = $clog2(COEF_W);
    localparam int ACC_W  = SMP_W + $clog2(TAPS + 1);

    logic              seq_accept, seq_busy;
    logic [CNT_W-1:0]  seq_cnt;
    phase_e            seq_phase;
    logic [TERM_W-1:0] seq_term;
    logic [BIT_W-1:0]  seq_bit;
    logic [COEF_W-1:0] cur_coef;

    assign smp_addr = seq_term;

    interp_seq #(
        .TAPS(TAPS), .COEF_W(COEF_W), .CNT_W(CNT_W),
        .SLOT_W(SLOT_W), .TERM_W(TERM_W), .BIT_W(BIT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(seq_accept), .busy(seq_busy), .step_cnt(seq_cnt),
        .phase(seq_phase), .term(seq_term), .bit_idx(seq_bit)
    );

    interp_coef_rf #(
        .TAPS(TAPS), .COEF_W(COEF_W), .TERM_W(TERM_W)
    ) u_rf (
        .clk(clk), .rst_n(rst_n), .we(wt_we), .waddr(wt_addr),
        .wdata(wt_data), .raddr(seq_term), .rdata(cur_coef)
    );

    interp_datapath #(
        .SMP_W(SMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .BIT_W(BIT_W)
    ) u_dp (
        .clk(clk), .rst_n(rst_n), .clr(seq_accept), .phase(seq_phase),
        .bit_idx(seq_bit), .coef(cur_coef), .smp_in(smp_data),
        .result(result), .done(done)
    );
endmodule

// File: rtl/interp_mac_chk.sv
module interp_mac_chk #(
    parameter int TAPS   = 7,
    parameter int CNT_W  = 8,
    parameter int SLOT_W = 4,
    parameter int TERM_W = 3,
    parameter int SMP_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [SMP_W-1:0]  result,
    input logic [TERM_W-1:0] smp_addr,
    input logic              busy,
    input logic [CNT_W-1:0]  step_cnt
);
    localparam logic [CNT_W-1:0] FIN_CNT = CNT_W'(TAPS << SLOT_W);
    localparam logic [CNT_W-1:0] BUDGET  = CNT_W'(128);

    AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> smp_addr == '0);                                          // R1
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step_cnt != FIN_CNT) |-> smp_addr < TERM_W'(TAPS));        // R4
    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step_cnt[SLOT_W-1:0] != '0) |-> $stable(smp_addr));       // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R5
    AST_DONE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(step_cnt) == FIN_CNT);                               // R5
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));                                         // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step_cnt != FIN_CNT) |=>
            (busy && step_cnt == CNT_W'($past(step_cnt) + 1'b1)));          // R6
    AST_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> step_cnt < BUDGET);                                        // R8
endmodule

bind interp_mac interp_mac_chk #(
    .TAPS(TAPS), .CNT_W(CNT_W), .SLOT_W(SLOT_W),
    .TERM_W($clog2(TAPS + 1)), .SMP_W(SMP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .result(result),
    .smp_addr(smp_addr), .busy(seq_busy), .step_cnt(seq_cnt)
);

// File: tb/sim_interp_mac.sv
module sim_interp_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wt_we = 1'b0;
    logic [2:0]  wt_addr = '0;
    logic [7:0]  wt_data = '0;
    logic [2:0]  smp_addr;
    logic [11:0] smp_data;
    logic [11:0] result;
    logic        done;

    logic signed [11:0] mem [7];
    int cf [7];
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    assign smp_data = (smp_addr < 3'd7) ? mem[smp_addr] : 12'd0;

    interp_mac u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wt_we(wt_we),
        .wt_addr(wt_addr), .wt_data(wt_data), .smp_addr(smp_addr),
        .smp_data(smp_data), .result(result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model();
        int s = 0;
        for (int k = 0; k < 7; k++) s += (int'(mem[k]) * cf[k]) >>> 8;
        if (s > 2047) s = 2047;
        if (s < -2048) s = -2048;
        return s;
    endfunction

    task automatic write_wt(input int addr, input int val);
        @(negedge clk);
        wt_we = 1'b1; wt_addr = 3'(addr); wt_data = 8'(val);
        @(negedge clk);
        wt_we = 1'b0;
        if (addr < 7) cf[addr] = int'($signed(8'(val)));
    endtask

    task automatic set_all(input int s, input int w);
        for (int k = 0; k < 7; k++) begin
            mem[k] = 12'(s);
            write_wt(k, w);
        end
    endtask

    // Run one computation; inject > 0 raises start again after that edge
    task automatic run_check(input string req, input int inject);
        int e = 0;
        int exp = model();
        logic [11:0] held;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        while (!done && e < 300) begin
            @(posedge clk);
            e++;
            @(negedge clk);
            start = (e == inject);
            if (!done && (e % 16) == 5 && (e / 16) < 7)
                chk(smp_addr == 3'(e / 16), "R4 address per slot", int'(smp_addr), e / 16);
        end
        start = 1'b0;
        chk(e == 113, "R5 done latency", e, 113);
        chk($signed(result) == exp, req, int'($signed(result)), exp);
        held = result;
        @(negedge clk);
        chk(!done, "R5 done single cycle", int'(done), 0);
        chk(result == held, "R5 result held", int'(result), int'(held));
    endtask

    task automatic t_reset();
        chk(result == 12'd0, "R1 reset result", int'(result), 0);
        chk(!done, "R1 reset done", int'(done), 0);
        chk(smp_addr == 3'd0, "R1 reset addr", int'(smp_addr), 0);
    endtask

    task automatic t_single_tap();
        set_all(0, 0);
        mem[0] = 12'sd100; write_wt(0, 64);
        run_check("R2 single tap 100*64", 0);
        mem[0] = -12'sd3; write_wt(0, 1);
        run_check("R2 floor of negative product", 0);
        mem[0] = -12'sd2048; write_wt(0, -128);
        run_check("R2 most negative operands", 0);
        set_all(0, 0);
        mem[6] = 12'sd1000; write_wt(6, -77);
        run_check("R4 last tap pairing", 0);
    endtask

    task automatic t_mixed();
        int seed = 12345;
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 7; k++) begin
                seed = seed * 1103515245 + 12345;
                mem[k] = 12'(seed >>> 8);
                seed = seed * 1103515245 + 12345;
                write_wt(k, (seed >>> 12) & 8'hFF);
            end
            run_check("R3 mixed pattern sum", 0);
        end
    endtask

    task automatic t_saturate();
        set_all(-2048, -128);
        run_check("R3 positive saturation", 0);
        set_all(2047, -128);
        run_check("R3 negative saturation", 0);
    endtask

    task automatic t_restart_ignored();
        set_all(300, 50);
        run_check("R6 start during run ignored", 40);
    endtask

    task automatic t_unused_addr();
        set_all(0, 0);
        for (int k = 0; k < 7; k++) mem[k] = 12'(100 * (k + 1));
        write_wt(2, 90);
        write_wt(7, 127);
        run_check("R7 write to address 7 ignored", 0);
        write_wt(2, -90);
        run_check("R7 weight reload takes effect", 0);
    endtask

    task automatic t_consecutive();
        set_all(1500, 127);
        run_check("R9 first of consecutive runs", 0);
        set_all(-7, 3);
        run_check("R9 running total cleared", 0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) begin mem[k] = '0; cf[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_single_tap();
        t_mixed();
        t_saturate();
        t_restart_ignored();
        t_unused_addr();
        t_consecutive();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule